// File: doc/BRIEF.md
# Packed Signed Halfword Maximum Unit

This block is a SIMD execution datapath. It takes two packed operands made of 16-bit two's-complement lanes and returns, in each lane, the larger of the two values compared as signed numbers. A lane from the first operand is written only when it is strictly larger than the matching lane of the second operand. In every other case, including equality, the second operand's lane is written.

A 2-bit mode input selects one of four forms. Two forms are destructive. In these the previous destination value acts as the first operand, and `src_a` is not used. The narrow destructive form works on 4 lanes and clears everything above them. The 128-bit destructive form works on 8 lanes and passes the old destination bits above them through unchanged. The other two forms are non-destructive and compare `src_a` against `src_b`. The 128-bit non-destructive form works on 8 lanes and clears the upper half. The full form works on all 16 lanes.

The 128-bit non-destructive form can carry an illegal vector-length bit. When that bit is set, the unit raises an undefined-encoding flag and writes no result. The result, the output strobe and the undefined flag are all registered one clock after the input strobe. The unit produces no other status and no numeric exceptions.

Top module: `hw_max_unit`

## Requirements
- R1: In each active lane, the output is the first operand's lane when it is greater than the second operand's lane under a signed 16-bit comparison. Otherwise the output is the second operand's lane. For example, 16'h8000 (-32768) loses to 16'h7FFF, and 16'hFFFF (-1) loses to 16'h0001.
- R2: With mode 2'b00 (narrow destructive), lanes 0 to 3 (bits 63:0) are the lane maxima of `prev_dst` and `src_b`, and bits 255:64 are zero.
- R3: With mode 2'b01 (128-bit destructive), lanes 0 to 7 are the lane maxima of `prev_dst` and `src_b`, and bits 255:128 equal `prev_dst[255:128]`.
- R4: With mode 2'b10 (128-bit non-destructive) and `len_bit` low, lanes 0 to 7 are the lane maxima of `src_a` and `src_b`, and bits 255:128 are zero.
- R5: With mode 2'b11 (full width), all 16 lanes are the lane maxima of `src_a` and `src_b`.
- R6: In modes 2'b00 and 2'b01, `src_a` has no effect on `res`.
- R7: With mode 2'b10 and `len_bit` high, `undef_flag` and `res_valid` are high on the following cycle and `res` keeps its previous value. In every other mode `len_bit` is ignored and `undef_flag` stays low.
- R8: `res_valid` is high exactly on the cycle after a cycle with `in_valid` high. When `in_valid` is low, `res` holds its value and `undef_flag` is low on the next cycle.
- R9: While `rst_n` is low, `res`, `res_valid` and `undef_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| mode | input | 2 | Form select: 00 narrow destructive, 01 128-bit destructive, 10 128-bit non-destructive, 11 full |
| len_bit | input | 1 | Vector-length encoding bit; illegal in mode 10 |
| src_a | input | 256 | First source (non-destructive forms) |
| src_b | input | 256 | Second source |
| prev_dst | input | 256 | Previous destination value |
| res | output | 256 | Registered result |
| res_valid | output | 1 | Registered strobe, one cycle after `in_valid` |
| undef_flag | output | 1 | Registered undefined-encoding flag |

## Verification
Every output of this unit is due exactly one rising edge after the cycle in which `in_valid` is presented. This covers the lane result, the output strobe and the undefined flag. The bench changes inputs on the falling edge, lets one rising edge pass, and reads all three outputs on the next falling edge. It then drops `in_valid`. For the hold cases, it waits a further full cycle before sampling again, so it observes that an idle cycle or an undefined encoding left `res` untouched.

// File: rtl/pmax_pkg.sv
package pmax_pkg;

  typedef enum logic [1:0] {
    MODE_NARROW = 2'b00,
    MODE_MERGE  = 2'b01,
    MODE_CLEAR  = 2'b10,
    MODE_WIDE   = 2'b11
  } pmax_mode_e;

endpackage

// File: rtl/pmax_opsel.sv
module pmax_opsel
  import pmax_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic [1:0]       mode,
  input  logic             len_bit,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] prev_dst,
  output logic [VEC_W-1:0] op_first,
  output logic             illegal
);

  pmax_mode_e mode_e;

  always_comb begin
    mode_e = pmax_mode_e'(mode);
    // destructive forms read the destination as their first operand
    if (mode_e == MODE_NARROW || mode_e == MODE_MERGE) op_first = prev_dst;
    else                                               op_first = src_a;
    illegal = (mode_e == MODE_CLEAR) && len_bit;
  end

endmodule

// File: rtl/pmax_cmp_array.sv
module pmax_cmp_array #(
  parameter int LANE_W    = 16,
  parameter int NUM_LANES = 16,
  localparam int VEC_W    = LANE_W * NUM_LANES
) (
  input  logic [VEC_W-1:0] op_x,
  input  logic [VEC_W-1:0] op_y,
  output logic [VEC_W-1:0] lane_max
);

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic signed [LANE_W-1:0] x_l;
    logic signed [LANE_W-1:0] y_l;
    logic                     x_wins;

    always_comb begin
      x_l    = op_x[i*LANE_W +: LANE_W];
      y_l    = op_y[i*LANE_W +: LANE_W];
      x_wins = x_l > y_l;  // strict: ties go to y
      lane_max[i*LANE_W +: LANE_W] = x_wins ? x_l : y_l;
    end
  end

endmodule

// File: rtl/pmax_merge.sv
module pmax_merge
  import pmax_pkg::*;
#(
  parameter int LANE_W       = 16,
  parameter int NUM_LANES    = 16,
  parameter int NARROW_LANES = 4,
  parameter int MID_LANES    = 8,
  localparam int VEC_W       = LANE_W * NUM_LANES
) (
  input  logic [1:0]       mode,
  input  logic [VEC_W-1:0] lane_max,
  input  logic [VEC_W-1:0] prev_dst,
  output logic [VEC_W-1:0] merged
);

  pmax_mode_e mode_e;
  assign mode_e = pmax_mode_e'(mode);

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam bit IN_NARROW = (i < NARROW_LANES);
    localparam bit IN_MID    = (i < MID_LANES);
    logic active;
    logic keep;

    always_comb begin
      active = 1'b0;
      keep   = 1'b0;
      unique case (mode_e)
        MODE_NARROW: active = IN_NARROW;
        MODE_MERGE: begin
          active = IN_MID;
          keep   = !IN_MID;
        end
        MODE_CLEAR:  active = IN_MID;
        MODE_WIDE:   active = 1'b1;
        default:     active = 1'b0;
      endcase
      if (active)    merged[i*LANE_W +: LANE_W] = lane_max[i*LANE_W +: LANE_W];
      else if (keep) merged[i*LANE_W +: LANE_W] = prev_dst[i*LANE_W +: LANE_W];
      else           merged[i*LANE_W +: LANE_W] = '0;
    end
  end

endmodule

// File: rtl/hw_max_unit.sv
module hw_max_unit #(
  parameter int LANE_W      = 16,
  parameter int NUM_LANES   = 16,
  parameter int NARROW_BITS = 64,
  parameter int MID_BITS    = 128,
  localparam int VEC_W        = LANE_W * NUM_LANES,
  localparam int NARROW_LANES = NARROW_BITS / LANE_W,
  localparam int MID_LANES    = MID_BITS / LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       mode,
  input  logic             len_bit,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] prev_dst,
  output logic [VEC_W-1:0] res,
  output logic             res_valid,
  output logic             undef_flag
);

  logic [VEC_W-1:0] op_first;
  logic             illegal;
  logic [VEC_W-1:0] lane_max;
  logic [VEC_W-1:0] merged;

  logic [VEC_W-1:0] res_q, res_d;
  logic             res_en;
  logic             vld_q, vld_d;
  logic             undef_q, undef_d;

  pmax_opsel #(.VEC_W(VEC_W)) u_opsel (
    .mode     (mode),
    .len_bit  (len_bit),
    .src_a    (src_a),
    .prev_dst (prev_dst),
    .op_first (op_first),
    .illegal  (illegal)
  );

  pmax_cmp_array #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_cmp (
    .op_x     (op_first),
    .op_y     (src_b),
    .lane_max (lane_max)
  );

  pmax_merge #(
    .LANE_W       (LANE_W),
    .NUM_LANES    (NUM_LANES),
    .NARROW_LANES (NARROW_LANES),
    .MID_LANES    (MID_LANES)
  ) u_merge (
    .mode     (mode),
    .lane_max (lane_max),
    .prev_dst (prev_dst),
    .merged   (merged)
  );

  // next-state
  always_comb begin
    res_en  = in_valid && !illegal;
    res_d   = merged;
    vld_d   = in_valid;
    undef_d = in_valid && illegal;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      vld_q   <= 1'b0;
      undef_q <= 1'b0;
    end else begin
      if (res_en) res_q <= res_d;
      vld_q   <= vld_d;
      undef_q <= undef_d;
    end
  end

  assign res        = res_q;
  assign res_valid  = vld_q;
  assign undef_flag = undef_q;

endmodule

// File: rtl/pmax_checker.sv
module pmax_checker #(
  parameter int VEC_W       = 256,
  parameter int NARROW_BITS = 64,
  parameter int MID_BITS    = 128
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic [1:0]                mode,
  input logic                      len_bit,
  input logic [VEC_W-1:MID_BITS]   prev_hi,
  input logic [VEC_W-1:0]          res,
  input logic                      res_valid,
  input logic                      undef_flag
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);                                            // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res) && !res_valid && !undef_flag));         // R8
  AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b10 && len_bit) |=> (undef_flag && $stable(res))); // R7
  AST_NO_UNDEF_ELSE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode != 2'b10) |=> !undef_flag);                       // R7
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b00) |=> (res[VEC_W-1:NARROW_BITS] == '0));  // R2
  AST_MERGE_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b01) |=> (res[VEC_W-1:MID_BITS] == $past(prev_hi))); // R3
  AST_CLEAR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b10 && !len_bit) |=> (res[VEC_W-1:MID_BITS] == '0)); // R4
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (res == '0 && !res_valid && !undef_flag));               // R9

endmodule

bind hw_max_unit pmax_checker #(
  .VEC_W       (VEC_W),
  .NARROW_BITS (NARROW_BITS),
  .MID_BITS    (MID_BITS)
) u_pmax_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .mode       (mode),
  .len_bit    (len_bit),
  .prev_hi    (prev_dst[VEC_W-1:MID_BITS]),
  .res        (res),
  .res_valid  (res_valid),
  .undef_flag (undef_flag)
);

// File: tb/hw_max_unit_test.sv
module hw_max_unit_test;

  localparam int W = 256;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   mode;
  logic         len_bit;
  logic [W-1:0] src_a, src_b, prev_dst;
  logic [W-1:0] res;
  logic         res_valid, undef_flag;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  hw_max_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .len_bit(len_bit), .src_a(src_a), .src_b(src_b), .prev_dst(prev_dst),
    .res(res), .res_valid(res_valid), .undef_flag(undef_flag)
  );

  function automatic logic [W-1:0] mk_vec(input int seed);
    logic [W-1:0] v;
    for (int i = 0; i < 16; i++)
      v[i*16 +: 16] = 16'(i * 16'h1357 + seed * 16'h9E37 + (seed << i));
    return v;
  endfunction

  // lane-wise signed max over the first nl lanes, zero above
  function automatic logic [W-1:0] ref_max(input logic [W-1:0] x,
                                           input logic [W-1:0] y,
                                           input int nl);
    logic [W-1:0] r = '0;
    for (int i = 0; i < nl; i++) begin
      if ($signed(x[i*16 +: 16]) > $signed(y[i*16 +: 16])) r[i*16 +: 16] = x[i*16 +: 16];
      else r[i*16 +: 16] = y[i*16 +: 16];
    end
    return r;
  endfunction

  task automatic chk_vec(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s res act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  // drive on falling edge, one rising edge, sample at next falling edge
  task automatic issue(input logic [1:0] m, input logic lb,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] p);
    mode = m; len_bit = lb; src_a = a; src_b = b; prev_dst = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; mode = 2'b00; len_bit = 1'b0;
    src_a = '0; src_b = '0; prev_dst = '0;
    repeat (3) @(negedge clk);
    chk_vec("R9 reset res", res, '0);
    chk_bit("R9 reset res_valid", res_valid, 1'b0);
    chk_bit("R9 reset undef_flag", undef_flag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_signed_corners();
    logic [W-1:0] a, b, e;
    for (int i = 0; i < 16; i++) begin
      case (i % 4)
        0: begin a[i*16 +: 16] = 16'h8000; b[i*16 +: 16] = 16'h7FFF; e[i*16 +: 16] = 16'h7FFF; end
        1: begin a[i*16 +: 16] = 16'hFFFF; b[i*16 +: 16] = 16'h0001; e[i*16 +: 16] = 16'h0001; end
        2: begin a[i*16 +: 16] = 16'h0000; b[i*16 +: 16] = 16'hFFFF; e[i*16 +: 16] = 16'h0000; end
        default: begin a[i*16 +: 16] = 16'h7FFF; b[i*16 +: 16] = 16'h7FFE; e[i*16 +: 16] = 16'h7FFF; end
      endcase
    end
    issue(2'b11, 1'b0, a, b, mk_vec(7));
    chk_vec("R1 signed corners", res, e);
    chk_bit("R8 valid after op", res_valid, 1'b1);
  endtask

  task automatic t_wide();
    for (int s = 1; s < 4; s++) begin
      logic [W-1:0] a = mk_vec(s), b = mk_vec(s + 11);
      issue(2'b11, 1'b0, a, b, mk_vec(s + 20));
      chk_vec("R5 full width", res, ref_max(a, b, 16));
    end
    begin
      logic [W-1:0] a = mk_vec(5), b = mk_vec(6);
      issue(2'b11, 1'b1, a, b, '0);  // len_bit ignored here
      chk_vec("R7 len_bit ignored mode 11", res, ref_max(a, b, 16));
      chk_bit("R7 no undef mode 11", undef_flag, 1'b0);
    end
  endtask

  task automatic t_narrow();
    logic [W-1:0] p = mk_vec(31), b = mk_vec(32);
    issue(2'b00, 1'b0, mk_vec(33), b, p);
    chk_vec("R2 narrow destructive", res, ref_max(p, b, 4));
    issue(2'b00, 1'b1, ~mk_vec(33), b, p);  // different src_a, len_bit set
    chk_vec("R6 src_a ignored mode 00", res, ref_max(p, b, 4));
    chk_bit("R7 no undef mode 00", undef_flag, 1'b0);
  endtask

  task automatic t_merge();
    logic [W-1:0] p = mk_vec(41), b = mk_vec(42), e;
    e = ref_max(p, b, 8);
    e[255:128] = p[255:128];
    issue(2'b01, 1'b0, mk_vec(43), b, p);
    chk_vec("R3 merge keeps upper", res, e);
    issue(2'b01, 1'b0, ~mk_vec(43), b, p);
    chk_vec("R6 src_a ignored mode 01", res, e);
  endtask

  task automatic t_clear();
    logic [W-1:0] a = mk_vec(51), b = mk_vec(52);
    issue(2'b10, 1'b0, a, b, ~'0);
    chk_vec("R4 clear upper", res, ref_max(a, b, 8));
    chk_bit("R4 no undef", undef_flag, 1'b0);
  endtask

  task automatic t_undef();
    logic [W-1:0] a = mk_vec(61), b = mk_vec(62), held;
    issue(2'b11, 1'b0, a, b, '0);
    held = ref_max(a, b, 16);
    issue(2'b10, 1'b1, mk_vec(63), mk_vec(64), mk_vec(65));
    chk_bit("R7 undef raised", undef_flag, 1'b1);
    chk_bit("R7 valid with undef", res_valid, 1'b1);
    chk_vec("R7 res held on undef", res, held);
    @(negedge clk);
    chk_bit("R8 undef clears when idle", undef_flag, 1'b0);
  endtask

  task automatic t_idle_hold();
    logic [W-1:0] a = mk_vec(71), b = mk_vec(72);
    issue(2'b11, 1'b0, a, b, '0);
    src_a = mk_vec(90); src_b = mk_vec(91); prev_dst = mk_vec(92); mode = 2'b11;
    repeat (2) @(negedge clk);
    chk_vec("R8 idle holds res", res, ref_max(a, b, 16));
    chk_bit("R8 idle no valid", res_valid, 1'b0);
  endtask

  initial begin
    t_reset();
    t_signed_corners();
    t_wide();
    t_narrow();
    t_merge();
    t_clear();
    t_undef();
    t_idle_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule